// File: doc/BRIEF.md
# Branch and Skip Next-PC Unit

This block works out where the program counter of a single-issue 8-bit microcontroller core goes after the current instruction. Each cycle the decoder gives it the current PC and a three-bit control-flow class, along with the operands that class needs. For relative transfers this is a signed offset. For conditional branches it is a status-register bit selector and a set/clear sense. For skips it is the tested bit and a flag saying whether the following instruction occupies two words. For returns it is the word at the top of the return stack.

From these the unit produces the next PC, a taken/skip indication and the number of clock cycles the instruction occupies. It also raises a push request carrying the return address for calls, a pop request for both kinds of return, and a request to set the global interrupt-enable flag on return-from-interrupt. It is purely combinational. The PC register, the stack storage, instruction fetch and the ALU sit outside it.

Top module: `bpc_nextpc`

## Requirements
- R1: Class 0 (sequential) gives next PC = PC + 1, taken 0, 1 cycle and no push, pop or interrupt-enable request. The flag inputs, the test bit and the long-next flag have no effect on it.
- R2: Class 1 (relative jump) gives next PC = PC + k + 1, taken 1 and 2 cycles. Here k is the offset input read as two's complement of OFS_W bits.
- R3: Class 2 (relative call) gives next PC = PC + k + 1, taken 1 and 3 cycles. It raises push, with the return-address output equal to PC + 1. Push and pop are never raised together.
- R4: Class 3 (return) gives next PC = stack-top input, taken 1 and 4 cycles, and raises pop without the interrupt-enable request.
- R5: Class 4 (return from interrupt) behaves as R4 and also raises the interrupt-enable set request. No other class raises that request.
- R6: Class 5 (conditional branch) tests status bit number flag_sel_i against flag_sense_i. The bit layout is C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. On a match the result is next PC = PC + k + 1 with 2 cycles and taken 1. Otherwise it is PC + 1 with 1 cycle and taken 0.
- R7: With SIGN_FROM_NV=1, selector 4 tests N xor V (status bits 2 and 3) and ignores the stored bit 4. Sense 0 gives signed greater-or-equal and sense 1 gives signed less-than.
- R8: Unsigned same-or-higher and lower are selector 0 with sense 0 and sense 1 respectively, so they are taken when C is clear or set.
- R9: Class 6 skips when test_bit_i is 0 and class 7 skips when it is 1. A skip that is not taken gives PC + 1, 1 cycle and taken 0.
- R10: A taken skip gives PC + 2 and 2 cycles when next_long_i is 0, and PC + 3 and 3 cycles when next_long_i is 1.
- R11: Every PC result wraps modulo 2^PC_W. This includes offsets whose magnitude exceeds the program memory size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Control-flow class (0..7 as in R1–R10) |
| pc_i | input | PC_W | Address of the current instruction |
| offset_i | input | OFS_W | Signed relative displacement k |
| flag_sel_i | input | 3 | Status bit index for conditional branches |
| flag_sense_i | input | 1 | 1: branch when the bit is set, 0: when clear |
| sreg_i | input | 8 | Status register |
| test_bit_i | input | 1 | Bit or equality result tested by skips |
| next_long_i | input | 1 | Instruction after the current one is two words |
| stack_top_i | input | PC_W | Return address popped from the stack |
| next_pc_o | output | PC_W | Address of the next instruction |
| taken_o | output | 1 | Control transfer or skip occurs |
| cycles_o | output | 3 | Clock cycles used by the instruction |
| push_o | output | 1 | Push ret_addr_o onto the return stack |
| ret_addr_o | output | PC_W | Return address PC + 1 |
| pop_o | output | 1 | Pop the return stack |
| int_en_set_o | output | 1 | Set the global interrupt-enable flag |

## Verification
The bench builds the block with its defaults: PC_W=9, OFS_W=12 and SIGN_FROM_NV=1. A 512-word space lets a handful of vectors cross the wrap point from both sides. An offset wider than the PC means the extreme displacements +2047 and -2048 wrap more than once. The derived sign bit is driven with N, V and the stored bit 4 set against each other, so a design that reads the stored bit takes the wrong direction.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

   typedef enum logic [2:0] {
      OP_SEQ      = 3'd0,
      OP_JUMP     = 3'd1,
      OP_CALL     = 3'd2,
      OP_RET      = 3'd3,
      OP_RETI     = 3'd4,
      OP_BRANCH   = 3'd5,
      OP_SKIP_CLR = 3'd6,
      OP_SKIP_SET = 3'd7
   } bpc_op_e;

   // status bit positions decoded by the branch selector
   localparam int unsigned FLAG_C = 0;
   localparam int unsigned FLAG_Z = 1;
   localparam int unsigned FLAG_N = 2;
   localparam int unsigned FLAG_V = 3;
   localparam int unsigned FLAG_S = 4;
   localparam int unsigned FLAG_I = 7;

   localparam int unsigned CYC_W = 3;

   localparam logic [CYC_W-1:0] CYC_ONE   = 3'd1;
   localparam logic [CYC_W-1:0] CYC_TWO   = 3'd2;
   localparam logic [CYC_W-1:0] CYC_THREE = 3'd3;
   localparam logic [CYC_W-1:0] CYC_FOUR  = 3'd4;

endpackage

// File: rtl/bpc_cond.sv
module bpc_cond
   import bpc_pkg::*;
#(
   parameter bit SIGN_FROM_NV = 1'b1
) (
   input  bpc_op_e    op_i,
   input  logic [2:0] flag_sel_i,
   input  logic       flag_sense_i,
   input  logic [7:0] sreg_i,
   input  logic       test_bit_i,
   output logic       take_o
);

   logic [7:0] flags;

   generate
      if (SIGN_FROM_NV) begin : g_sign_nv
         // bit S replaced by N xor V; the stored S cancels out
         always_comb begin
            flags = sreg_i ^ (8'(sreg_i[FLAG_S] ^ sreg_i[FLAG_N] ^ sreg_i[FLAG_V]) << FLAG_S);
         end
      end else begin : g_sign_stored
         always_comb begin
            flags = sreg_i;
         end
      end
   endgenerate

   always_comb begin
      case (op_i)
         OP_JUMP, OP_CALL, OP_RET, OP_RETI: take_o = 1'b1;
         OP_BRANCH:   take_o = (flags[flag_sel_i] == flag_sense_i);
         OP_SKIP_CLR: take_o = ~test_bit_i;
         OP_SKIP_SET: take_o = test_bit_i;
         default:     take_o = 1'b0;
      endcase
   end

   always_comb begin
      if (!$isunknown({op_i, flag_sel_i, flag_sense_i, sreg_i})) begin
         if (op_i == OP_BRANCH && flag_sel_i == 3'(FLAG_S) && SIGN_FROM_NV)
            assert_signed_nv_R7: assert (take_o == ((sreg_i[FLAG_N] ^ sreg_i[FLAG_V]) == flag_sense_i));
      end
   end

endmodule

// File: rtl/bpc_target.sv
module bpc_target #(
   parameter int unsigned PC_W  = 9,
   parameter int unsigned OFS_W = 12
) (
   input  logic [PC_W-1:0]  pc_i,
   input  logic [OFS_W-1:0] offset_i,
   output logic [PC_W-1:0]  plus1_o,
   output logic [PC_W-1:0]  plus2_o,
   output logic [PC_W-1:0]  plus3_o,
   output logic [PC_W-1:0]  rel_o
);

   localparam int unsigned SUM_W = (PC_W > OFS_W) ? PC_W : OFS_W;

   logic [SUM_W-1:0] ofs_ext;
   logic [SUM_W-1:0] pc_ext;

   always_comb begin
      ofs_ext = SUM_W'($signed(offset_i));
      pc_ext  = SUM_W'(pc_i);
      plus1_o = pc_i + PC_W'(1);
      plus2_o = pc_i + PC_W'(2);
      plus3_o = pc_i + PC_W'(3);
      rel_o   = PC_W'(pc_ext + ofs_ext + SUM_W'(1));
   end

   always_comb begin
      if (!$isunknown(pc_i)) begin
         assert_skip_step_R10: assert (PC_W'(plus3_o - plus2_o) == PC_W'(plus2_o - plus1_o));
      end
   end

endmodule

// File: rtl/bpc_cost.sv
module bpc_cost
   import bpc_pkg::*;
(
   input  bpc_op_e          op_i,
   input  logic             take_i,
   input  logic             next_long_i,
   output logic [CYC_W-1:0] cycles_o
);

   always_comb begin
      case (op_i)
         OP_SEQ:           cycles_o = CYC_ONE;
         OP_JUMP:          cycles_o = CYC_TWO;
         OP_CALL:          cycles_o = CYC_THREE;
         OP_RET, OP_RETI:  cycles_o = CYC_FOUR;
         OP_BRANCH:        cycles_o = take_i ? CYC_TWO : CYC_ONE;
         OP_SKIP_CLR, OP_SKIP_SET:
            cycles_o = !take_i ? CYC_ONE : (next_long_i ? CYC_THREE : CYC_TWO);
         default:          cycles_o = CYC_ONE;
      endcase
   end

   always_comb begin
      if (!$isunknown({op_i, take_i, next_long_i})) begin
         assert_cycle_range_R2: assert (cycles_o >= CYC_ONE && cycles_o <= CYC_FOUR);
      end
   end

endmodule

// File: rtl/bpc_nextpc.sv
module bpc_nextpc
   import bpc_pkg::*;
#(
   parameter int unsigned PC_W         = 9,
   parameter int unsigned OFS_W        = 12,
   parameter bit          SIGN_FROM_NV = 1'b1
) (
   input  logic [2:0]       op_i,
   input  logic [PC_W-1:0]  pc_i,
   input  logic [OFS_W-1:0] offset_i,
   input  logic [2:0]       flag_sel_i,
   input  logic             flag_sense_i,
   input  logic [7:0]       sreg_i,
   input  logic             test_bit_i,
   input  logic             next_long_i,
   input  logic [PC_W-1:0]  stack_top_i,
   output logic [PC_W-1:0]  next_pc_o,
   output logic             taken_o,
   output logic [2:0]       cycles_o,
   output logic             push_o,
   output logic [PC_W-1:0]  ret_addr_o,
   output logic             pop_o,
   output logic             int_en_set_o
);

   generate
      if (PC_W < 2 || PC_W > 22) begin : g_bad_pc
         $error("bpc_nextpc: PC_W must lie in 2..22");
      end
      if (OFS_W < 2) begin : g_bad_ofs
         $error("bpc_nextpc: OFS_W must be at least 2");
      end
   endgenerate

   bpc_op_e         op;
   logic            take;
   logic [PC_W-1:0] plus1, plus2, plus3, rel;

   assign op = bpc_op_e'(op_i);

   bpc_cond #(.SIGN_FROM_NV(SIGN_FROM_NV)) u_cond (
      .op_i         (op),
      .flag_sel_i   (flag_sel_i),
      .flag_sense_i (flag_sense_i),
      .sreg_i       (sreg_i),
      .test_bit_i   (test_bit_i),
      .take_o       (take)
   );

   bpc_target #(.PC_W(PC_W), .OFS_W(OFS_W)) u_target (
      .pc_i     (pc_i),
      .offset_i (offset_i),
      .plus1_o  (plus1),
      .plus2_o  (plus2),
      .plus3_o  (plus3),
      .rel_o    (rel)
   );

   bpc_cost u_cost (
      .op_i        (op),
      .take_i      (take),
      .next_long_i (next_long_i),
      .cycles_o    (cycles_o)
   );

   always_comb begin
      case (op)
         OP_SEQ:          next_pc_o = plus1;
         OP_JUMP, OP_CALL: next_pc_o = rel;
         OP_RET, OP_RETI: next_pc_o = stack_top_i;
         OP_BRANCH:       next_pc_o = take ? rel : plus1;
         OP_SKIP_CLR, OP_SKIP_SET:
            next_pc_o = !take ? plus1 : (next_long_i ? plus3 : plus2);
         default:         next_pc_o = plus1;
      endcase
   end

   assign taken_o      = take;
   assign push_o       = (op == OP_CALL);
   assign pop_o        = (op == OP_RET) || (op == OP_RETI);
   assign int_en_set_o = (op == OP_RETI);
   assign ret_addr_o   = plus1;

   always_comb begin
      if (!$isunknown({op_i, pc_i, offset_i, flag_sel_i, flag_sense_i,
                       sreg_i, test_bit_i, next_long_i, stack_top_i})) begin
         assert_stack_excl_R3: assert ($onehot0({push_o, pop_o}));
         assert_ie_needs_pop_R5: assert (!int_en_set_o || pop_o);
         if (op == OP_SEQ)
            assert_seq_plain_R1: assert (!taken_o && cycles_o == 3'd1);
         if (op == OP_BRANCH)
            assert_branch_cost_R6: assert (cycles_o == (taken_o ? 3'd2 : 3'd1));
         if ((op == OP_SKIP_CLR || op == OP_SKIP_SET) && taken_o)
            assert_skip_span_R10: assert (PC_W'(next_pc_o - pc_i) == PC_W'(cycles_o));
      end
   end

endmodule

// File: tb/bpc_nextpc_bench.sv
module bpc_nextpc_bench;

   localparam int unsigned PC_W  = 9;
   localparam int unsigned OFS_W = 12;

   logic clk = 1'b0;
   always #4 clk = ~clk;  // 125 MHz

   logic [2:0]       op;
   logic [PC_W-1:0]  pc;
   logic [OFS_W-1:0] ofs;
   logic [2:0]       sel;
   logic             sense;
   logic [7:0]       sreg;
   logic             tbit;
   logic             lng;
   logic [PC_W-1:0]  stk;
   logic [PC_W-1:0]  next_pc;
   logic             taken;
   logic [2:0]       cycles;
   logic             push;
   logic [PC_W-1:0]  ret_addr;
   logic             pop;
   logic             ie_set;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   bpc_nextpc #(.PC_W(PC_W), .OFS_W(OFS_W), .SIGN_FROM_NV(1'b1)) u_bpc_nextpc (
      .op_i(op), .pc_i(pc), .offset_i(ofs), .flag_sel_i(sel), .flag_sense_i(sense),
      .sreg_i(sreg), .test_bit_i(tbit), .next_long_i(lng), .stack_top_i(stk),
      .next_pc_o(next_pc), .taken_o(taken), .cycles_o(cycles), .push_o(push),
      .ret_addr_o(ret_addr), .pop_o(pop), .int_en_set_o(ie_set)
   );

   typedef struct packed {
      logic [7:0]  req;
      logic [2:0]  op;
      logic [8:0]  pc;
      logic [11:0] ofs;
      logic [2:0]  sel;
      logic        sense;
      logic [7:0]  sreg;
      logic        tbit;
      logic        lng;
      logic [8:0]  stk;
      logic [8:0]  e_nxt;
      logic        e_tk;
      logic [2:0]  e_cyc;
      logic        e_psh;
      logic        e_pop;
      logic        e_ie;
   } vec_t;

   localparam int NV = 25;
   localparam vec_t TBL [NV] = '{
      // req op  pc      ofs       sel  sn  sreg   tb  lg  stk     nxt     tk  cyc   ps  po  ie
      '{8'd1,  3'd0, 9'd10,  12'd0,    3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 9'd0,   9'd11,  1'b0, 3'd1, 1'b0, 1'b0, 1'b0}, // R1
      '{8'd11, 3'd0, 9'd511, 12'd0,    3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 9'd0,   9'd0,   1'b0, 3'd1, 1'b0, 1'b0, 1'b0}, // R11
      '{8'd2,  3'd1, 9'd100, 12'd20,   3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 9'd0,   9'd121, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0}, // R2
      '{8'd2,  3'd1, 9'd100, 12'hFCE,  3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 9'd0,   9'd51,  1'b1, 3'd2, 1'b0, 1'b0, 1'b0}, // R2 k=-50
      '{8'd11, 3'd1, 9'd500, 12'd30,   3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 9'd0,   9'd19,  1'b1, 3'd2, 1'b0, 1'b0, 1'b0}, // R11
      '{8'd11, 3'd1, 9'd3,   12'hFF6,  3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 9'd0,   9'd506, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0}, // R11 k=-10
      '{8'd3,  3'd2, 9'd40,  12'd7,    3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 9'd0,   9'd48,  1'b1, 3'd3, 1'b1, 1'b0, 1'b0}, // R3
      '{8'd4,  3'd3, 9'd77,  12'd0,    3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 9'd300, 9'd300, 1'b1, 3'd4, 1'b0, 1'b1, 1'b0}, // R4
      '{8'd5,  3'd4, 9'd77,  12'd0,    3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 9'd5,   9'd5,   1'b1, 3'd4, 1'b0, 1'b1, 1'b1}, // R5
      '{8'd6,  3'd5, 9'd50,  12'd10,   3'd1, 1'b1, 8'h02, 1'b0, 1'b0, 9'd0,   9'd61,  1'b1, 3'd2, 1'b0, 1'b0, 1'b0}, // R6 Z set
      '{8'd6,  3'd5, 9'd50,  12'd10,   3'd1, 1'b0, 8'h02, 1'b0, 1'b0, 9'd0,   9'd51,  1'b0, 3'd1, 1'b0, 1'b0, 1'b0}, // R6 not taken
      '{8'd6,  3'd5, 9'd50,  12'hFFB,  3'd7, 1'b1, 8'h80, 1'b0, 1'b0, 9'd0,   9'd46,  1'b1, 3'd2, 1'b0, 1'b0, 1'b0}, // R6 I set
      '{8'd7,  3'd5, 9'd200, 12'd3,    3'd4, 1'b0, 8'h1C, 1'b0, 1'b0, 9'd0,   9'd204, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0}, // R7 ge
      '{8'd7,  3'd5, 9'd200, 12'd3,    3'd4, 1'b1, 8'h04, 1'b0, 1'b0, 9'd0,   9'd204, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0}, // R7 lt
      '{8'd7,  3'd5, 9'd200, 12'd3,    3'd4, 1'b1, 8'h10, 1'b0, 1'b0, 9'd0,   9'd201, 1'b0, 3'd1, 1'b0, 1'b0, 1'b0}, // R7 stored S ignored
      '{8'd8,  3'd5, 9'd10,  12'd2,    3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 9'd0,   9'd13,  1'b1, 3'd2, 1'b0, 1'b0, 1'b0}, // R8 same/higher
      '{8'd8,  3'd5, 9'd10,  12'd2,    3'd0, 1'b1, 8'h00, 1'b0, 1'b0, 9'd0,   9'd11,  1'b0, 3'd1, 1'b0, 1'b0, 1'b0}, // R8 lower, C=0
      '{8'd8,  3'd5, 9'd10,  12'd2,    3'd0, 1'b1, 8'h01, 1'b0, 1'b0, 9'd0,   9'd13,  1'b1, 3'd2, 1'b0, 1'b0, 1'b0}, // R8 lower, C=1
      '{8'd9,  3'd6, 9'd30,  12'd0,    3'd0, 1'b0, 8'h00, 1'b1, 1'b0, 9'd0,   9'd31,  1'b0, 3'd1, 1'b0, 1'b0, 1'b0}, // R9
      '{8'd9,  3'd6, 9'd30,  12'd0,    3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 9'd0,   9'd32,  1'b1, 3'd2, 1'b0, 1'b0, 1'b0}, // R9
      '{8'd10, 3'd7, 9'd30,  12'd0,    3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 9'd0,   9'd33,  1'b1, 3'd3, 1'b0, 1'b0, 1'b0}, // R10 long
      '{8'd9,  3'd7, 9'd30,  12'd0,    3'd0, 1'b0, 8'h00, 1'b0, 1'b1, 9'd0,   9'd31,  1'b0, 3'd1, 1'b0, 1'b0, 1'b0}, // R9
      '{8'd11, 3'd7, 9'd510, 12'd0,    3'd0, 1'b0, 8'h00, 1'b1, 1'b1, 9'd0,   9'd1,   1'b1, 3'd3, 1'b0, 1'b0, 1'b0}, // R11
      '{8'd10, 3'd6, 9'd100, 12'd0,    3'd0, 1'b0, 8'h00, 1'b0, 1'b1, 9'd0,   9'd103, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0}, // R10
      '{8'd1,  3'd0, 9'd10,  12'd99,   3'd3, 1'b1, 8'hFF, 1'b1, 1'b1, 9'd77,  9'd11,  1'b0, 3'd1, 1'b0, 1'b0, 1'b0}  // R1 extras ignored
   };

   task automatic drive(input vec_t v);
      op = v.op; pc = v.pc; ofs = v.ofs; sel = v.sel; sense = v.sense;
      sreg = v.sreg; tbit = v.tbit; lng = v.lng; stk = v.stk;
      #2;
   endtask

   task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp, input string what);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL R%0d %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   initial begin
      op = 3'd0; pc = '0; ofs = '0; sel = '0; sense = 1'b0;
      sreg = '0; tbit = 1'b0; lng = 1'b0; stk = '0;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         v = TBL[i];
         @(negedge clk);
         drive(v);
         check(int'(v.req),
               {17'd0, next_pc, taken, cycles, push, pop, ie_set},
               {17'd0, v.e_nxt, v.e_tk, v.e_cyc, v.e_psh, v.e_pop, v.e_ie},
               "vector {next,taken,cycles,push,pop,ie}");
         if (v.e_psh)
            check(3, 32'(ret_addr), 32'(9'(v.pc + 9'd1)), "return address"); // R3
      end

      // R2 / R11: extreme displacements wrap more than once
      @(negedge clk);
      drive('{8'd2, 3'd1, 9'd0, 12'h7FF, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 9'd0,
              9'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0});
      check(11, 32'(next_pc), 32'd0, "k=+2047 from 0");
      @(negedge clk);
      drive('{8'd2, 3'd1, 9'd0, 12'h800, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 9'd0,
              9'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0});
      check(2, 32'(next_pc), 32'd1, "k=-2048 from 0");

      // R5 / R3: interrupt-enable only on class 4, never push with pop
      for (int c = 0; c < 8; c++) begin
         @(negedge clk);
         drive('{8'd5, 3'(c), 9'd42, 12'd5, 3'd0, 1'b1, 8'hFF, 1'b1, 1'b1, 9'd9,
                 9'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0});
         check(5, {29'd0, ie_set, push, pop},
               {29'd0, (c == 4), (c == 2), (c == 3 || c == 4)}, "ie/push/pop per class");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule